// File: doc/BRIEF.md
# Wave Wait-Counter Unit

This unit keeps the outstanding-operation accounting for one wave and decides when a wave that has stopped to wait on its memory traffic may issue again. Three 6-bit counters track three classes of operation: vector memory, export, and local/scalar memory. Each counter rises by one when an operation of its class is issued and falls by one when one completes. A wait instruction first arms the unit, which blocks issue, and then loads one threshold per class. The wave stays blocked until every threshold in use is met by its counter. Then all thresholds are dropped and the wave runs again.

A second, independent mechanism puts the wave to sleep for a number of checks. The sleep count is taken only when no sleep is in progress. Each check pulse lowers it by one. When it reaches zero the unit gives a one-cycle completion pulse and lets the wave issue again.

Misuse is flagged with one-cycle error pulses. One covers loading thresholds on top of thresholds that are still in use. The other covers a counter that would go below zero or above its maximum.

Top module: `wave_wait_unit`

## Requirements
- R1: After reset every counter reads 0, `ready` is 1, no threshold is in use, no sleep is in progress, and `err_set`, `err_count` and `sleep_done` are 0.
- R2: An `inc_*` pulse without the matching `dec_*` raises that counter by one, and a `dec_*` pulse without `inc_*` lowers it by one. The new value is visible after the clock edge that samples the pulse.
- R3: An increment and a decrement of the same counter in the same cycle leave its value unchanged.
- R4: A decrement of a counter at 0 with no increment leaves it at 0. An increment of a counter at 63 with no decrement leaves it at 63. Either case gives `err_count` = 1 in the following cycle.
- R5: `wait_arm` moves a running wave to the armed state. While armed, and after a threshold load, `ready` is 0 until the release condition of R7 is met.
- R6: The thresholds are 4 bits for vector memory (`thr_vmem`), 3 bits for export (`thr_exp`) and 5 bits for local/scalar memory (`thr_lsm`). A field of all ones (15, 7, 31) marks that threshold as unused, and an unused threshold never holds the wave.
- R7: In the waiting state, the release happens at the first clock edge where every threshold in use is greater than or equal to its counter's value before that edge. At that edge all thresholds become unused and `ready` is 1 after it. A load with every field unused therefore releases at the edge after the load.
- R8: A `wait_set` while any threshold is in use gives `err_set` = 1 in the next cycle and leaves the stored thresholds unchanged.
- R9: `sleep_load` takes `sleep_amount` only while the sleep count is 0. It is ignored while a sleep is in progress. `ready` is 0 while the sleep count is non-zero.
- R10: Each `sleep_check` lowers a non-zero sleep count by one. The check that brings it to 0 gives `sleep_done` = 1 in the next cycle and lets `ready` return to 1. A check at count 0 gives no `sleep_done` and does not change `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_vmem | input | 1 | Vector memory operation issued |
| dec_vmem | input | 1 | Vector memory operation completed |
| inc_exp | input | 1 | Export operation issued |
| dec_exp | input | 1 | Export operation completed |
| inc_lsm | input | 1 | Local/scalar memory operation issued |
| dec_lsm | input | 1 | Local/scalar memory operation completed |
| wait_arm | input | 1 | Enter the armed wait state |
| wait_set | input | 1 | Load the three thresholds |
| thr_vmem | input | 4 | Vector memory threshold, 15 = unused |
| thr_exp | input | 3 | Export threshold, 7 = unused |
| thr_lsm | input | 5 | Local/scalar threshold, 31 = unused |
| sleep_load | input | 1 | Load the sleep count |
| sleep_amount | input | 8 | Sleep count to load |
| sleep_check | input | 1 | One sleep check |
| ready | output | 1 | Wave may issue |
| cnt_vmem | output | 6 | Vector memory count |
| cnt_exp | output | 6 | Export count |
| cnt_lsm | output | 6 | Local/scalar count |
| sleep_done | output | 1 | Pulse when the sleep count reaches 0 |
| err_set | output | 1 | Pulse on a threshold load over active thresholds |
| err_count | output | 1 | Pulse on counter underflow or overflow |

## Verification
The hardest case to reach is the exact edge of release. The wave must be waiting with a counter sitting one above, at, and one below its threshold, for every threshold value of every field width. The bench sweeps each class through all active threshold values. For each one it builds the count with increment pulses, arms and loads, and then drains the counter one completion at a time. At each step it predicts from the arithmetic alone the cycle in which `ready` must rise. The 63-count overflow edge is reached by a long run of increments. Loading over live thresholds is reached by holding a wave with a count above a zero threshold.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    WS_RUN   = 2'd0,
    WS_ARMED = 2'd1,
    WS_WAIT  = 2'd2
  } wait_state_t;

  // Next value of a saturating up/down counter of width up to 16.
  function automatic logic [15:0] step_count(input logic [15:0] cur,
                                             input logic up,
                                             input logic down,
                                             input logic [15:0] top);
    logic [15:0] r;
    r = cur;
    if (up && !down && cur != top) r = cur + 16'd1;
    else if (down && !up && cur != 16'd0) r = cur - 16'd1;
    return r;
  endfunction

  // A threshold in use is met when the count does not exceed it.
  function automatic logic within_limit(input logic [15:0] cnt,
                                        input logic [15:0] lim,
                                        input logic in_use);
    return !in_use || (cnt <= lim);
  endfunction

endpackage

// File: rtl/wc_counter.sv
module wc_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] value,
  output logic         fault
);
  import wc_pkg::*;

  localparam logic [W-1:0] TOP = '1;

  logic overflow_ev;
  logic underflow_ev;
  logic [15:0] nxt16;

  assign overflow_ev  = up && !down && (value == TOP);
  assign underflow_ev = down && !up && (value == '0);
  assign nxt16 = step_count(16'(value), up, down, 16'(TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      fault <= 1'b0;
    end else begin
      value <= nxt16[W-1:0];
      fault <= overflow_ev || underflow_ev;
    end
  end

  a_r3_same_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up && down) |=> $stable(value));

  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !up && value == '0) |=> (fault && value == '0));

  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && value == TOP) |=> (fault && value == TOP));

  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && value != TOP) |=> (value == $past(value) + 1'b1));

endmodule

// File: rtl/wc_thresh.sv
module wc_thresh #(
  parameter int FW = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [FW-1:0] field,
  input  logic [CW-1:0] count,
  output logic          in_use,
  output logic          met
);
  import wc_pkg::*;

  localparam logic [FW-1:0] UNUSED = '1;

  logic [FW-1:0] limit;

  assign met = within_limit(16'(count), 16'(limit), in_use);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_use <= 1'b0;
      limit  <= UNUSED;
    end else if (load) begin
      in_use <= (field != UNUSED);
      limit  <= field;
    end else if (clear) begin
      in_use <= 1'b0;
      limit  <= UNUSED;
    end
  end

  a_r6_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (load && field == UNUSED) |=> !in_use);

  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> !in_use);

endmodule

// File: rtl/wc_sleep.sv
module wc_sleep #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] amount,
  input  logic          check,
  output logic          busy,
  output logic          done
);
  logic [SW-1:0] remain;
  logic          take_load;
  logic          take_check;

  assign busy       = (remain != '0);
  assign take_load  = load && !busy;
  assign take_check = check && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      if (take_load)       remain <= amount;
      else if (take_check) remain <= remain - 1'b1;
      done <= take_check && (remain == SW'(1));
    end
  end

  a_r10_idle_check: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && check && !load) |=> (!busy && !done));

  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !check) |=> $stable(remain));

  a_r10_last_check: assert property (@(posedge clk) disable iff (!rst_n)
    (check && remain == SW'(1)) |=> (done && !busy));

endmodule

// File: rtl/wc_gate.sv
module wc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic set,
  input  logic any_in_use,
  input  logic all_met,
  output logic load_thr,
  output logic release_ev,
  output logic running,
  output logic set_fault
);
  import wc_pkg::*;

  wait_state_t state;
  wait_state_t state_nxt;
  logic bad_set;

  assign bad_set    = set && any_in_use;
  assign load_thr   = set && !any_in_use;
  assign release_ev = (state == WS_WAIT) && all_met;
  assign running    = (state == WS_RUN);

  always_comb begin
    state_nxt = state;
    unique case (state)
      WS_RUN:   if (load_thr) state_nxt = WS_WAIT;
                else if (arm) state_nxt = WS_ARMED;
      WS_ARMED: if (load_thr) state_nxt = WS_WAIT;
      WS_WAIT:  if (load_thr) state_nxt = WS_WAIT;
                else if (release_ev) state_nxt = WS_RUN;
      default:  state_nxt = WS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_RUN;
      set_fault <= 1'b0;
    end else begin
      state     <= state_nxt;
      set_fault <= bad_set;
    end
  end

  a_r5_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ARMED && !set) |=> (state == WS_ARMED));

  a_r8_set_over_active: assert property (@(posedge clk) disable iff (!rst_n)
    (set && any_in_use) |=> set_fault);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && !set) |=> running);

  a_r5_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_WAIT && !all_met) |=> !running);

endmodule

// File: rtl/wave_wait_unit.sv
module wave_wait_unit #(
  parameter int CNT_W  = 6,
  parameter int VMEM_W = 4,
  parameter int EXP_W  = 3,
  parameter int LSM_W  = 5,
  parameter int SLP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_vmem,
  input  logic              dec_vmem,
  input  logic              inc_exp,
  input  logic              dec_exp,
  input  logic              inc_lsm,
  input  logic              dec_lsm,
  input  logic              wait_arm,
  input  logic              wait_set,
  input  logic [VMEM_W-1:0] thr_vmem,
  input  logic [EXP_W-1:0]  thr_exp,
  input  logic [LSM_W-1:0]  thr_lsm,
  input  logic              sleep_load,
  input  logic [SLP_W-1:0]  sleep_amount,
  input  logic              sleep_check,
  output logic              ready,
  output logic [CNT_W-1:0]  cnt_vmem,
  output logic [CNT_W-1:0]  cnt_exp,
  output logic [CNT_W-1:0]  cnt_lsm,
  output logic              sleep_done,
  output logic              err_set,
  output logic              err_count
);
  localparam int NCLS = 3;

  logic [NCLS-1:0]  up_bus;
  logic [NCLS-1:0]  down_bus;
  logic [NCLS-1:0]  fault_bus;
  logic [CNT_W-1:0] cnt_bus [NCLS];
  logic [NCLS-1:0]  use_bus;
  logic [NCLS-1:0]  met_bus;

  logic load_thr;
  logic release_ev;
  logic running;
  logic sleeping;
  logic any_in_use;
  logic all_met;

  assign up_bus   = {inc_lsm, inc_exp, inc_vmem};
  assign down_bus = {dec_lsm, dec_exp, dec_vmem};

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    wc_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .up   (up_bus[g]),
      .down (down_bus[g]),
      .value(cnt_bus[g]),
      .fault(fault_bus[g])
    );
  end

  assign cnt_vmem  = cnt_bus[0];
  assign cnt_exp   = cnt_bus[1];
  assign cnt_lsm   = cnt_bus[2];
  assign err_count = |fault_bus;

  wc_thresh #(.FW(VMEM_W), .CW(CNT_W)) u_thr_vmem (
    .clk(clk), .rst_n(rst_n), .load(load_thr), .clear(release_ev),
    .field(thr_vmem), .count(cnt_bus[0]), .in_use(use_bus[0]), .met(met_bus[0]));

  wc_thresh #(.FW(EXP_W), .CW(CNT_W)) u_thr_exp (
    .clk(clk), .rst_n(rst_n), .load(load_thr), .clear(release_ev),
    .field(thr_exp), .count(cnt_bus[1]), .in_use(use_bus[1]), .met(met_bus[1]));

  wc_thresh #(.FW(LSM_W), .CW(CNT_W)) u_thr_lsm (
    .clk(clk), .rst_n(rst_n), .load(load_thr), .clear(release_ev),
    .field(thr_lsm), .count(cnt_bus[2]), .in_use(use_bus[2]), .met(met_bus[2]));

  assign any_in_use = |use_bus;
  assign all_met    = &met_bus;

  wc_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (wait_arm),
    .set       (wait_set),
    .any_in_use(any_in_use),
    .all_met   (all_met),
    .load_thr  (load_thr),
    .release_ev(release_ev),
    .running   (running),
    .set_fault (err_set)
  );

  wc_sleep #(.SW(SLP_W)) u_sleep (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sleep_load),
    .amount(sleep_amount),
    .check (sleep_check),
    .busy  (sleeping),
    .done  (sleep_done)
  );

  assign ready = running && !sleeping;

  a_r7_thresholds_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && !wait_set) |=> !any_in_use);

  a_r8_keep_on_bad_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_set && any_in_use && !release_ev) |=> $stable(use_bus));

  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !sleep_check) |=> !ready);

endmodule

// File: tb/sim_wave_wait_unit.sv
module sim_wave_wait_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_vmem = 0, dec_vmem = 0, inc_exp = 0, dec_exp = 0, inc_lsm = 0, dec_lsm = 0;
  logic wait_arm = 0, wait_set = 0;
  logic [3:0] thr_vmem = 4'hF;
  logic [2:0] thr_exp = 3'h7;
  logic [4:0] thr_lsm = 5'h1F;
  logic sleep_load = 0, sleep_check = 0;
  logic [7:0] sleep_amount = 8'd0;
  logic ready, sleep_done, err_set, err_count;
  logic [5:0] cnt_vmem, cnt_exp, cnt_lsm;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wave_wait_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .inc_vmem(inc_vmem), .dec_vmem(dec_vmem), .inc_exp(inc_exp), .dec_exp(dec_exp),
    .inc_lsm(inc_lsm), .dec_lsm(dec_lsm), .wait_arm(wait_arm), .wait_set(wait_set),
    .thr_vmem(thr_vmem), .thr_exp(thr_exp), .thr_lsm(thr_lsm),
    .sleep_load(sleep_load), .sleep_amount(sleep_amount), .sleep_check(sleep_check),
    .ready(ready), .cnt_vmem(cnt_vmem), .cnt_exp(cnt_exp), .cnt_lsm(cnt_lsm),
    .sleep_done(sleep_done), .err_set(err_set), .err_count(err_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    inc_vmem = 0; dec_vmem = 0; inc_exp = 0; dec_exp = 0; inc_lsm = 0; dec_lsm = 0;
    wait_arm = 0; wait_set = 0; sleep_load = 0; sleep_check = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
  endtask

  task automatic drive_cls(input int cls, input bit up, input bit down);
    inc_vmem = (cls == 0) && up; dec_vmem = (cls == 0) && down;
    inc_exp  = (cls == 1) && up; dec_exp  = (cls == 1) && down;
    inc_lsm  = (cls == 2) && up; dec_lsm  = (cls == 2) && down;
  endtask

  task automatic pulses(input int cls, input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      drive_cls(cls, up, !up);
      step();
    end
    quiet();
  endtask

  function automatic int count_of(input int cls);
    return (cls == 0) ? int'(cnt_vmem) : (cls == 1) ? int'(cnt_exp) : int'(cnt_lsm);
  endfunction

  function automatic int unused_code(input int cls);
    return (cls == 0) ? 15 : (cls == 1) ? 7 : 31;
  endfunction

  task automatic load_thr(input int v, input int e, input int l);
    thr_vmem = 4'(v); thr_exp = 3'(e); thr_lsm = 5'(l);
    wait_set = 1;
    step();
    wait_set = 0;
  endtask

  // Sweep: count n against threshold t for one class (R2, R5, R6, R7).
  task automatic sweep_point(input int cls, input int t, input int n);
    do_reset();
    pulses(cls, 1'b1, n);
    chk("R2 count after increments", count_of(cls), n);
    wait_arm = 1;
    step();
    wait_arm = 0;
    chk("R5 armed blocks ready", ready, 0);
    load_thr(cls == 0 ? t : 15, cls == 1 ? t : 7, cls == 2 ? t : 31);
    chk("R5 loaded not yet released", ready, 0);
    step();
    chk("R7 release decision", ready, (n <= t) ? 1 : 0);
    if (n > t) begin
      pulses(cls, 1'b0, n - t);
      chk("R2 count after decrements", count_of(cls), t);
      chk("R7 held until count seen at limit", ready, 0);
      step();
      chk("R7 released at limit", ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt_vmem", cnt_vmem, 0);
    chk("R1 cnt_exp", cnt_exp, 0);
    chk("R1 cnt_lsm", cnt_lsm, 0);
    chk("R1 ready", ready, 1);
    chk("R1 err_set", err_set, 0);
    chk("R1 err_count", err_count, 0);
    chk("R1 sleep_done", sleep_done, 0);

    // Threshold sweep for every class and every active value
    for (int cls = 0; cls < 3; cls++) begin
      for (int t = 0; t < unused_code(cls); t++) begin
        for (int n = t - 1; n <= t + 1; n++) begin
          if (n >= 0) sweep_point(cls, t, n);
        end
      end
    end

    // R3: simultaneous increment and decrement
    do_reset();
    pulses(1, 1'b1, 3);
    inc_exp = 1; dec_exp = 1;
    step();
    quiet();
    chk("R3 exp unchanged", cnt_exp, 3);
    chk("R3 no error", err_count, 0);

    // R4: underflow and overflow
    do_reset();
    dec_lsm = 1;
    step();
    quiet();
    chk("R4 underflow error", err_count, 1);
    chk("R4 underflow value", cnt_lsm, 0);
    step();
    chk("R4 error is a pulse", err_count, 0);
    pulses(0, 1'b1, 63);
    chk("R4 reached top", cnt_vmem, 63);
    chk("R4 no error at top", err_count, 0);
    inc_vmem = 1;
    step();
    quiet();
    chk("R4 overflow error", err_count, 1);
    chk("R4 overflow value", cnt_vmem, 63);

    // R6: all fields unused releases at once despite nonzero counts
    do_reset();
    pulses(0, 1'b1, 9);
    pulses(1, 1'b1, 4);
    pulses(2, 1'b1, 20);
    wait_arm = 1;
    step();
    wait_arm = 0;
    load_thr(15, 7, 31);
    chk("R6 all unused waiting", ready, 0);
    step();
    chk("R6 all unused releases", ready, 1);

    // R7: multi-class, release only when the last active limit is met
    do_reset();
    pulses(0, 1'b1, 3);
    pulses(1, 1'b1, 2);
    pulses(2, 1'b1, 5);
    wait_arm = 1;
    step();
    wait_arm = 0;
    load_thr(1, 2, 4);
    pulses(2, 1'b0, 1);
    step();
    chk("R7 lsm met, vmem not", ready, 0);
    pulses(0, 1'b0, 2);
    step();
    chk("R7 all met", ready, 1);

    // R8: load over active thresholds
    do_reset();
    pulses(0, 1'b1, 1);
    wait_arm = 1;
    step();
    wait_arm = 0;
    load_thr(0, 7, 31);
    chk("R8 no error on first load", err_set, 0);
    load_thr(5, 7, 31);
    chk("R8 error on second load", err_set, 1);
    step();
    chk("R8 old threshold kept", ready, 0);
    pulses(0, 1'b0, 1);
    step();
    chk("R8 release with old threshold", ready, 1);
    chk("R8 error is a pulse", err_set, 0);

    // R9 and R10: sleep
    do_reset();
    sleep_check = 1;
    step();
    quiet();
    chk("R10 check at zero no done", sleep_done, 0);
    chk("R10 check at zero ready", ready, 1);
    sleep_amount = 8'd5; sleep_load = 1;
    step();
    quiet();
    chk("R9 sleeping blocks ready", ready, 0);
    sleep_amount = 8'd40; sleep_load = 1;
    step();
    quiet();
    for (int k = 1; k <= 5; k++) begin
      sleep_check = 1;
      step();
      quiet();
      chk("R10 done on last check only", sleep_done, (k == 5) ? 1 : 0);
      chk("R9 reload ignored, ready timing", ready, (k == 5) ? 1 : 0);
    end
    sleep_check = 1;
    step();
    quiet();
    chk("R10 later check at zero", sleep_done, 0);
    chk("R10 ready stays", ready, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule